// File: doc/BRIEF.md
# Dual-Channel Potentiometer Wiper Controller

This block is the digital core of a two-channel, 256-step digital potentiometer. Each channel keeps an 8-bit volatile wiper code, which drives the resistor ladder, and an 8-bit non-volatile shadow code. The non-volatile storage is modelled here as plain registers. A host loads and moves these codes over a write-only SPI slave link. The link uses mode 0 with an active-low chip select, and each frame is 16 bits.

The four commands are: load a wiper, load a shadow, copy wiper to shadow, and copy shadow to wiper. The two commands that program the shadow start a timed busy period. While that period runs, further shadow programming is refused, but recall from the shadow into a wiper stays available. After reset, each shadow holds a default code, and the controller copies that code into its wiper on the first clock.

The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are detected on the synchronized copies. Because of this, SCLK high time, SCLK low time and chip-select high time must each last several system clocks.

Top module: `pot_wiper_ctrl`

## Requirements
- R1: When reset is released, every shadow register holds NV_DEFAULT (0x80 by default), every wiper holds that same value one clock later, and busy_o is low.
- R2: A frame is 16 bits, shifted MSB first on SCLK rising edges while cs_ni is low. Bits [15:14] are the command, bit [13] selects the channel (0 = channel 0, 1 = channel 1), bits [12:8] are ignored whatever their value, and bits [7:0] are the data code.
- R3: A command executes only on the rising edge of cs_ni, and only if exactly 16 SCLK rising edges were seen while cs_ni was low. Frames of any other length are dropped.
- R4: Command 00 loads the data code into the selected channel's wiper. The other channel's wiper does not change.
- R5: Command 01 loads the data code into the selected channel's shadow register and starts a busy period. Other shadows do not change.
- R6: Command 10 copies the selected channel's wiper into its shadow register and starts a busy period.
- R7: Command 11 copies the selected channel's shadow register into its wiper. This command is accepted even while busy_o is high.
- R8: After an accepted command 01 or 10, busy_o stays high for exactly BUSY_CYCLES system clocks.
- R9: While busy_o is high, commands 01 and 10 are ignored. They change no shadow register and do not extend the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idle low, asynchronous |
| cs_ni | input | 1 | Active-low frame select, asynchronous |
| din_i | input | 1 | Serial data, MSB first |
| wiper_o | output | NUM_CH×CODE_W (16) | Wiper codes; channel c sits at [c*8 +: 8] |
| busy_o | output | 1 | Shadow programming in progress |

## Verification
The bench sweeps every code through channel 0's wiper and checks that channel 1 holds its value throughout. It then shows that the reserved bits have no effect, and that 15-bit and 17-bit frames are dropped. A design that counted bits loosely would act on those short and long frames. Shadow contents are observed by recalling them into a wiper. This exposes a controller that lets writes through while busy, or that starts a new busy period for a refused command; the second fault also shows up as a busy period longer than BUSY_CYCLES. Recall is issued during the busy period, so a design that blocks all commands while busy would leave the wiper stale. A reset in the middle of a busy period must bring back the default code in both the wiper and the shadow, and must clear busy.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [1:0] {
    CMD_WR_WIPER = 2'b00,
    CMD_WR_NV    = 2'b01,
    CMD_CP_W2NV  = 2'b10,
    CMD_CP_NV2W  = 2'b11
  } pot_cmd_e;
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pot_spi_rx.sv
module pot_spi_rx
  import pot_pkg::*;
#(
  parameter int CH_W   = 1,
  parameter int RSV_W  = 5,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  output logic              vld_o,
  output pot_cmd_e          cmd_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [CODE_W-1:0] data_o
);
  localparam int FRAME_W = 2 + CH_W + RSV_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclk_s, cs_s, din_s;
  logic sclk_d, cs_d;
  logic sclk_rise, cs_rise;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;

  pot_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sclk (.clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s));
  pot_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_cs   (.clk_i, .rst_ni, .d_i(cs_ni),  .q_o(cs_s));
  pot_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_din  (.clk_i, .rst_ni, .d_i(din_i),  .q_o(din_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_s & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_s) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      shift_q <= {shift_q[FRAME_W-2:0], din_s};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= cs_rise && (cnt_q == CNT_FULL);
  end

  // fields are stable: no shifting while chip select is high
  assign cmd_o  = pot_cmd_e'(shift_q[FRAME_W-1 -: 2]);
  assign ch_o   = shift_q[CODE_W+RSV_W +: CH_W];
  assign data_o = shift_q[CODE_W-1:0];

  p_vld_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  p_vld_on_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> cs_s);
endmodule

// File: rtl/pot_busy_timer.sv
module pot_busy_timer #(
  parameter int BUSY_CYCLES = 4_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_start_sets_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/pot_chan_regs.sv
module pot_chan_regs #(
  parameter int                CODE_W     = 8,
  parameter logic [CODE_W-1:0] NV_DEFAULT = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              recall_i,
  input  logic              wiper_we_i,
  input  logic [CODE_W-1:0] wiper_d_i,
  input  logic              nv_we_i,
  input  logic [CODE_W-1:0] nv_d_i,
  output logic [CODE_W-1:0] wiper_o,
  output logic [CODE_W-1:0] nv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wiper_o <= '0;
    else if (recall_i)   wiper_o <= nv_o;
    else if (wiper_we_i) wiper_o <= wiper_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nv_o <= NV_DEFAULT;
    else if (nv_we_i) nv_o <= nv_d_i;
  end

  p_recall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_i |=> wiper_o == $past(nv_o));
  p_wiper_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wiper_we_i && !recall_i) |=> wiper_o == $past(wiper_d_i));
endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
  import pot_pkg::*;
#(
  parameter int                NUM_CH      = 2,
  parameter int                CODE_W      = 8,
  parameter int                RSV_W       = 5,
  parameter logic [CODE_W-1:0] NV_DEFAULT  = 8'h80,
  parameter int                BUSY_CYCLES = 4_000_000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sclk_i,
  input  logic                         cs_ni,
  input  logic                         din_i,
  output logic [NUM_CH-1:0][CODE_W-1:0] wiper_o,
  output logic                         busy_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              vld;
  pot_cmd_e          cmd;
  logic [CH_W-1:0]   ch;
  logic [CODE_W-1:0] data;
  logic              recall_q;
  logic              nv_op;
  logic [NUM_CH-1:0][CODE_W-1:0] nv;

  pot_spi_rx #(.CH_W(CH_W), .RSV_W(RSV_W), .CODE_W(CODE_W)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i,
    .vld_o(vld), .cmd_o(cmd), .ch_o(ch), .data_o(data)
  );

  // one-shot shadow-to-wiper recall after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recall_q <= 1'b1;
    else         recall_q <= 1'b0;
  end

  assign nv_op = vld && !busy_o && (cmd == CMD_WR_NV || cmd == CMD_CP_W2NV);

  pot_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(nv_op), .busy_o
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              sel;
    logic              wiper_we;
    logic              nv_we;
    logic [CODE_W-1:0] wiper_d;
    logic [CODE_W-1:0] nv_d;

    assign sel      = (ch == CH_W'(c));
    assign wiper_we = vld && sel && (cmd == CMD_WR_WIPER || cmd == CMD_CP_NV2W);
    assign wiper_d  = (cmd == CMD_CP_NV2W) ? nv[c] : data;
    assign nv_we    = nv_op && sel;
    assign nv_d     = (cmd == CMD_CP_W2NV) ? wiper_o[c] : data;

    pot_chan_regs #(.CODE_W(CODE_W), .NV_DEFAULT(NV_DEFAULT)) u_regs (
      .clk_i, .rst_ni,
      .recall_i(recall_q),
      .wiper_we_i(wiper_we), .wiper_d_i(wiper_d),
      .nv_we_i(nv_we), .nv_d_i(nv_d),
      .wiper_o(wiper_o[c]), .nv_o(nv[c])
    );

    p_nv_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> $stable(nv[c]));
    p_recall_any_time_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld && sel && cmd == CMD_CP_NV2W && !recall_q) |=> wiper_o[c] == $past(nv[c]));
  end
endmodule

// File: tb/tb_pot_wiper_ctrl.sv
module tb_pot_wiper_ctrl;
  localparam int BUSY = 2000;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [1:0][7:0] wiper;
  logic busy;

  int n_run = 0, n_fail = 0;
  int cyc = 0, t_rise = 0, t_fall = 0;
  logic busy_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pot_wiper_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .wiper_o(wiper), .busy_o(busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (busy && !busy_prev) t_rise = cyc;
    if (!busy && busy_prev) t_fall = cyc;
    busy_prev = busy;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] cmd, input logic ch,
                                      input logic [7:0] d, input logic [4:0] rsv = 5'd0);
    return {16'd0, cmd, ch, rsv, d};
  endfunction

  task automatic send(input logic [31:0] w, input int nbits = 16);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      din = w[nbits-1-i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    wait_clk(2);
  endtask

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(4);
    chk("R1 wiper0 after reset", wiper[0], 8'h80);
    chk("R1 wiper1 after reset", wiper[1], 8'h80);
    chk("R1 busy after reset", busy, 0);

    // R4: full sweep on channel 0, channel 1 must hold
    for (int v = 0; v < 256; v++) begin
      send(mk(2'b00, 1'b0, 8'(v)));
      chk("R4 wiper0 load", wiper[0], v);
      chk("R4 wiper1 untouched", wiper[1], 8'h80);
    end
    for (int v = 0; v < 256; v += 17) begin
      send(mk(2'b00, 1'b1, 8'(v)));
      chk("R4 wiper1 load", wiper[1], v);
      chk("R4 wiper0 untouched", wiper[0], 8'hFF);
    end

    // R2: reserved bits have no effect
    send(mk(2'b00, 1'b1, 8'h5A, 5'b11111));
    chk("R2 reserved ignored", wiper[1], 8'h5A);
    chk("R2 other channel", wiper[0], 8'hFF);

    // R3: wrong lengths dropped
    send(mk(2'b00, 1'b0, 8'h11), 15);
    chk("R3 15-bit frame dropped", wiper[0], 8'hFF);
    chk("R3 15-bit frame dropped ch1", wiper[1], 8'h5A);
    send({15'd0, 1'b0, mk(2'b00, 1'b0, 8'h22)} , 17);
    chk("R3 17-bit frame dropped", wiper[0], 8'hFF);
    chk("R3 no busy from bad frame", busy, 0);

    // R5 / R7 / R9 / R8
    send(mk(2'b01, 1'b1, 8'h3C));
    chk("R5 busy after NV write", busy, 1);
    chk("R5 wiper1 not touched by NV write", wiper[1], 8'h5A);
    send(mk(2'b11, 1'b1, 8'h00));
    chk("R7 recall while busy", wiper[1], 8'h3C);
    send(mk(2'b01, 1'b1, 8'h55));
    send(mk(2'b10, 1'b0, 8'h00));
    chk("R9 still busy", busy, 1);
    wait_idle();
    chk("R8 busy length", t_fall - t_rise, BUSY);
    send(mk(2'b11, 1'b1, 8'h00));
    chk("R9 NV write ignored while busy", wiper[1], 8'h3C);
    send(mk(2'b11, 1'b0, 8'h00));
    chk("R9 copy-to-NV ignored while busy", wiper[0], 8'h80);
    chk("R9 no busy from recall", busy, 0);

    // R6
    send(mk(2'b00, 1'b0, 8'hA5));
    send(mk(2'b10, 1'b0, 8'h00));
    chk("R6 busy after copy", busy, 1);
    wait_idle();
    chk("R8 busy length copy", t_fall - t_rise, BUSY);
    send(mk(2'b00, 1'b0, 8'h00));
    chk("R4 wiper0 cleared", wiper[0], 8'h00);
    send(mk(2'b11, 1'b0, 8'h00));
    chk("R6 copied value recalled", wiper[0], 8'hA5);
    send(mk(2'b11, 1'b1, 8'h00));
    chk("R6 other shadow kept", wiper[1], 8'h3C);

    // R1: reset during busy
    send(mk(2'b01, 1'b0, 8'h77));
    chk("R5 busy before reset", busy, 1);
    rst_ni = 1'b0;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(4);
    chk("R1 busy cleared", busy, 0);
    chk("R1 wiper0 default", wiper[0], 8'h80);
    chk("R1 wiper1 default", wiper[1], 8'h80);
    send(mk(2'b11, 1'b0, 8'h00));
    chk("R1 shadow0 default", wiper[0], 8'h80);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule